// File: doc/BRIEF.md
# Sinusoidal Excitation Analyzer

This block watches a stream of signed 16-bit samples of a sine-wave excitation signal. The samples arrive at a fixed rate. From them it derives four results. The first is a timestamp for every rising zero crossing, refined below one sample. The second is the period between successive crossings. The third is the average of the per-cycle peak amplitudes over groups of eight cycles. The fourth is a flag that says whether a credible excitation is present. A multichannel system places one copy of the block on each channel.

Samples enter on a valid/ready stream. A sample transfers on a clock edge where `s_valid` and `s_ready` are both high. The source must then hold the sample and `s_valid` until that edge occurs. After a rising crossing is accepted, the block lowers `s_ready` while a sequential divider computes the sub-sample fraction. A source that cannot stall must therefore supply samples no faster than one every ten clocks. All results are registered. The crossing timestamp, the period and the averaged peak each come with a one-cycle strobe. The period window and the amplitude threshold are parameters, given in samples and in ADC codes.

Top module: `exc_analyzer`

## Requirements
- R1: `s_ready` is 1 out of reset. It goes low on the cycle after a crossing sample is accepted and stays low until the cycle in which that crossing's result is published. Samples are consumed only on edges where `s_valid` and `s_ready` are both 1.
- R2: A crossing is detected only when the previously accepted sample is negative (sign bit 1) and the current accepted sample is zero or positive. `xing_stb` pulses for exactly one cycle, 9 clock edges after the edge that accepted the crossing sample.
- R3: `xing_ts` holds two fields. The upper CNT_W bits hold the index of the last negative sample a, counted from 0 over accepted samples since reset and wrapping modulo 2^CNT_W. The low 8 bits hold floor(256·(−a)/(b−a)), where b is the first non-negative sample. When b is 0 the fraction is clamped to 255.
- R4: `period` is the difference, modulo 2^(CNT_W+8), between this crossing's timestamp and the previous one. `period_stb` pulses together with `xing_stb`, except on the first crossing after reset or after a timeout.
- R5: The peak of a cycle is the largest sample from the crossing sample b that starts the cycle up to the sample just before the next crossing.
- R6: Each crossing closes one cycle, except the first crossing after reset or after a timeout. At every 8th closed cycle, `peak_avg` becomes (sum of the 8 cycle peaks) >> 3 and `peak_stb` pulses together with `xing_stb`. The sum then starts again from zero.
- R7: At each period measurement, the period qualifier is set if the period lies within PER_MIN·256 to PER_MAX·256 inclusive, and cleared otherwise.
- R8: At each peak-average update, the amplitude qualifier is set if the average is strictly greater than AMP_MIN, and cleared otherwise.
- R9: `present` is 1 exactly when both qualifiers are set. It changes only on the edge that publishes a result, or on a timeout.
- R10: A timeout occurs when PER_MAX+1 non-crossing samples are accepted after the last crossing. From the next cycle `present` is 0, the peak sum and cycle count are cleared, and the next crossing counts as a first crossing.
- R11: Out of reset, every strobe, `present` and every data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | DATA_W | Signed excitation sample |
| xing_stb | output | 1 | New crossing timestamp |
| xing_ts | output | CNT_W+8 | Sample index and 8-bit fraction of crossing |
| period_stb | output | 1 | New period value |
| period | output | CNT_W+8 | Crossing-to-crossing period, 1/256 sample units |
| peak_stb | output | 1 | New averaged peak |
| peak_avg | output | DATA_W | Mean of 8 per-cycle peaks |
| present | output | 1 | Excitation qualified as present |

## Verification
Three results can change on the same edge. On the crossing that closes the eighth cycle, the timestamp, the period and the averaged peak are all published together, and both presence qualifiers can change. The bench provokes this with continuous sine bursts of several amplitudes and periods. These include non-integer periods, gaps in `s_valid`, a sample exactly at zero, and a stretch that forces a timeout. On every clock, the bench compares all outputs and `s_ready` against a behavioural model that applies all of that edge's updates together. A misordered update therefore shows up as a one-cycle mismatch in `present` or in a strobe.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // fraction bits appended to the sample index of a crossing
  localparam int FRAC_W   = 8;
  // log2 of the number of cycles averaged per peak result
  localparam int AVG_LOG2 = 3;
endpackage

// File: rtl/exc_xdet.sv
module exc_xdet #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic signed [DATA_W-1:0] din,
  output logic                     xing,
  output logic [CNT_W-1:0]         idx_a,
  output logic [DATA_W:0]          num,
  output logic [DATA_W:0]          den,
  output logic signed [DATA_W-1:0] cyc_peak
);
  logic signed [DATA_W-1:0] prev;
  logic signed [DATA_W-1:0] run_max;
  logic                     prev_vld;
  logic [CNT_W-1:0]         cnt;
  logic [DATA_W:0]          prev_x;
  logic [DATA_W:0]          cur_x;

  assign prev_x   = {prev[DATA_W-1], prev};
  assign cur_x    = {din[DATA_W-1], din};
  assign xing     = take && prev_vld && prev[DATA_W-1] && !din[DATA_W-1];
  assign idx_a    = cnt - CNT_W'(1);
  assign num      = '0 - prev_x;
  assign den      = cur_x - prev_x;
  assign cyc_peak = run_max;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev     <= '0;
      prev_vld <= 1'b0;
      cnt      <= '0;
      run_max  <= '0;
    end else if (take) begin
      prev     <= din;
      prev_vld <= 1'b1;
      cnt      <= cnt + CNT_W'(1);
      if (xing)               run_max <= din;
      else if (din > run_max) run_max <= din;
    end
  end
endmodule

// File: rtl/exc_frac_div.sv
module exc_frac_div #(
  parameter int W = 17,
  parameter int F = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [F-1:0] q
);
  localparam int SW = $clog2(F + 1);

  logic [W-1:0]  rem;
  logic [W-1:0]  dv;
  logic [F-1:0]  qr;
  logic          sat;
  logic          busy;
  logic [SW-1:0] step;
  logic [W:0]    rem2;
  logic          ge;

  assign rem2 = {rem, 1'b0};
  assign ge   = rem2 >= {1'b0, dv};
  assign q    = sat ? '1 : qr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      dv   <= '0;
      qr   <= '0;
      sat  <= 1'b0;
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= num;
        dv   <= den;
        sat  <= (num == den);
        qr   <= '0;
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (ge) rem <= W'(rem2 - {1'b0, dv});
        else    rem <= rem2[W-1:0];
        qr <= {qr[F-2:0], ge};
        if (step == SW'(F - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/exc_peak_avg.sv
module exc_peak_avg #(
  parameter int PK_W = 16,
  parameter int L    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            add,
  input  logic [PK_W-1:0] pk,
  output logic            fin,
  output logic [PK_W-1:0] avg_nxt,
  output logic            avg_stb,
  output logic [PK_W-1:0] avg
);
  localparam int AW = PK_W + L;

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;
  logic [L-1:0]  n;

  assign sum     = acc + AW'(pk);
  assign fin     = add && (n == '1);
  assign avg_nxt = PK_W'(sum >> L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      n       <= '0;
      avg     <= '0;
      avg_stb <= 1'b0;
    end else begin
      avg_stb <= 1'b0;
      if (clr) begin
        acc <= '0;
        n   <= '0;
      end else if (add) begin
        if (fin) begin
          acc     <= '0;
          n       <= '0;
          avg     <= avg_nxt;
          avg_stb <= 1'b1;
        end else begin
          acc <= sum;
          n   <= n + L'(1);
        end
      end
    end
  end
endmodule

// File: rtl/exc_presence.sv
module exc_presence #(
  parameter int CNT_W   = 24,
  parameter int TS_W    = 32,
  parameter int FRAC_W  = 8,
  parameter int PK_W    = 16,
  parameter int PER_MIN = 20,
  parameter int PER_MAX = 2000,
  parameter int AMP_MIN = 3277
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            xing,
  input  logic            armed,
  input  logic            per_vld,
  input  logic [TS_W-1:0] per,
  input  logic            amp_vld,
  input  logic [PK_W-1:0] amp,
  output logic            tmo,
  output logic            present
);
  localparam logic [CNT_W-1:0] GAP_LIM = CNT_W'(PER_MAX);
  localparam logic [TS_W-1:0]  PER_LO  = TS_W'(PER_MIN) << FRAC_W;
  localparam logic [TS_W-1:0]  PER_HI  = TS_W'(PER_MAX) << FRAC_W;
  localparam logic [PK_W-1:0]  AMP_TH  = PK_W'(AMP_MIN);

  logic [CNT_W-1:0] gap;
  logic             per_ok;
  logic             amp_ok;

  assign tmo     = take && !xing && armed && (gap == GAP_LIM);
  assign present = per_ok && amp_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap    <= '0;
      per_ok <= 1'b0;
      amp_ok <= 1'b0;
    end else begin
      if (take) begin
        if (xing)              gap <= '0;
        else if (armed && !tmo) gap <= gap + CNT_W'(1);
      end
      if (tmo) begin
        per_ok <= 1'b0;
        amp_ok <= 1'b0;
      end else begin
        if (per_vld) per_ok <= (per >= PER_LO) && (per <= PER_HI);
        if (amp_vld) amp_ok <= (amp > AMP_TH);
      end
    end
  end
endmodule

// File: rtl/exc_analyzer.sv
module exc_analyzer #(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 24,
  parameter int PER_MIN = 20,
  parameter int PER_MAX = 2000,
  parameter int AMP_MIN = 3277
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           s_valid,
  output logic                           s_ready,
  input  logic [DATA_W-1:0]              s_data,
  output logic                           xing_stb,
  output logic [CNT_W+exc_pkg::FRAC_W-1:0] xing_ts,
  output logic                           period_stb,
  output logic [CNT_W+exc_pkg::FRAC_W-1:0] period,
  output logic                           peak_stb,
  output logic [DATA_W-1:0]              peak_avg,
  output logic                           present
);
  import exc_pkg::*;

  localparam int TS_W = CNT_W + FRAC_W;

  logic                     busy;
  logic                     take;
  logic                     xing;
  logic [CNT_W-1:0]         idx_a;
  logic [DATA_W:0]          num;
  logic [DATA_W:0]          den;
  logic signed [DATA_W-1:0] cyc_peak;
  logic                     div_done;
  logic [FRAC_W-1:0]        frac;
  logic [CNT_W-1:0]         snap_idx;
  logic                     snap_first;
  logic [DATA_W-1:0]        snap_pk;
  logic                     have_last;
  logic [TS_W-1:0]          last_ts;
  logic [TS_W-1:0]          new_ts;
  logic [TS_W-1:0]          new_per;
  logic                     commit;
  logic                     pk_fin;
  logic [DATA_W-1:0]        pk_nxt;
  logic                     tmo;

  assign s_ready = !busy;
  assign take    = s_valid && s_ready;
  assign new_ts  = {snap_idx, frac};
  assign new_per = new_ts - last_ts;
  assign commit  = div_done && !snap_first;

  exc_xdet #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_xdet (
    .clk(clk), .rst_n(rst_n), .take(take), .din($signed(s_data)),
    .xing(xing), .idx_a(idx_a), .num(num), .den(den), .cyc_peak(cyc_peak)
  );

  exc_frac_div #(.W(DATA_W + 1), .F(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(xing), .num(num), .den(den),
    .done(div_done), .q(frac)
  );

  exc_peak_avg #(.PK_W(DATA_W), .L(AVG_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_n), .clr(tmo), .add(commit), .pk(snap_pk),
    .fin(pk_fin), .avg_nxt(pk_nxt), .avg_stb(peak_stb), .avg(peak_avg)
  );

  exc_presence #(
    .CNT_W(CNT_W), .TS_W(TS_W), .FRAC_W(FRAC_W), .PK_W(DATA_W),
    .PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .AMP_MIN(AMP_MIN)
  ) u_pres (
    .clk(clk), .rst_n(rst_n), .take(take), .xing(xing), .armed(have_last),
    .per_vld(commit), .per(new_per), .amp_vld(pk_fin), .amp(pk_nxt),
    .tmo(tmo), .present(present)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      snap_idx   <= '0;
      snap_first <= 1'b1;
      snap_pk    <= '0;
      have_last  <= 1'b0;
      last_ts    <= '0;
      xing_stb   <= 1'b0;
      xing_ts    <= '0;
      period_stb <= 1'b0;
      period     <= '0;
    end else begin
      xing_stb   <= 1'b0;
      period_stb <= 1'b0;
      if (xing) begin
        busy       <= 1'b1;
        snap_idx   <= idx_a;
        snap_first <= !have_last;
        snap_pk    <= cyc_peak;
        have_last  <= 1'b1;
      end else if (tmo) begin
        have_last  <= 1'b0;
      end
      if (div_done) begin
        busy     <= 1'b0;
        xing_stb <= 1'b1;
        xing_ts  <= new_ts;
        last_ts  <= new_ts;
        if (!snap_first) begin
          period_stb <= 1'b1;
          period     <= new_per;
        end
      end
    end
  end
endmodule

// File: rtl/exc_analyzer_chk.sv
module exc_analyzer_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic xing_stb,
  input logic period_stb,
  input logic peak_stb,
  input logic present
);
  // R2
  xing_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xing_stb |=> !xing_stb);

  // R1
  stall_before_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xing_stb |-> $past(!s_ready));

  // R1
  ready_drop_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_ready) |-> $past(s_valid));

  // R4
  period_with_xing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_stb |-> xing_stb);

  // R6
  peak_with_xing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak_stb |-> xing_stb);

  // R9
  present_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present) |-> (period_stb || peak_stb));
endmodule

bind exc_analyzer exc_analyzer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .xing_stb(xing_stb), .period_stb(period_stb), .peak_stb(peak_stb),
  .present(present)
);

// File: tb/tb_exc_analyzer.sv
module tb_exc_analyzer;
  localparam int DATA_W  = 16;
  localparam int CNT_W   = 10;
  localparam int PER_MIN = 10;
  localparam int PER_MAX = 120;
  localparam int AMP_MIN = 3277;
  localparam int TS_W    = CNT_W + 8;
  localparam int CMASK   = (1 << CNT_W) - 1;
  localparam int TMASK   = (1 << TS_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [DATA_W-1:0] s_data = '0;
  logic xing_stb, period_stb, peak_stb, present;
  logic [TS_W-1:0] xing_ts, period;
  logic [DATA_W-1:0] peak_avg;

  always #2.5 clk = ~clk;

  exc_analyzer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PER_MIN(PER_MIN),
                 .PER_MAX(PER_MAX), .AMP_MIN(AMP_MIN)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .xing_stb(xing_stb), .xing_ts(xing_ts),
    .period_stb(period_stb), .period(period), .peak_stb(peak_stb),
    .peak_avg(peak_avg), .present(present)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int m_prev = 0, m_cnt = 0, m_gap = 0, m_max = 0, m_pend = 0;
  bit m_pvld = 0, m_have = 0, p_first = 0, m_perok = 0, m_ampok = 0;
  int p_ts = 0, p_cpk = 0, m_last = 0, m_acc = 0, m_n = 0;
  bit e_xs = 0, e_ps = 0, e_ks = 0;
  int e_ts = 0, e_per = 0, e_avg = 0;
  int seen_ts = 0, seen_avg = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_done();
    int per;
    e_xs = 1; e_ts = p_ts;
    if (!p_first) begin
      per = (p_ts - m_last) & TMASK;
      e_ps = 1; e_per = per;
      m_perok = (per >= PER_MIN * 256) && (per <= PER_MAX * 256);
      m_acc += p_cpk; m_n++;
      if (m_n == 8) begin
        e_avg = m_acc >> 3; e_ks = 1;
        m_ampok = (e_avg > AMP_MIN);
        m_acc = 0; m_n = 0;
      end
    end
    m_last = p_ts;
  endtask

  task automatic model_step(bit acc, int x);
    e_xs = 0; e_ps = 0; e_ks = 0;
    if (m_pend > 0) begin
      m_pend--;
      if (m_pend == 0) model_done();
    end else if (acc) begin
      if (m_pvld && m_prev < 0 && x >= 0) begin
        int frac;
        frac = (x == 0) ? 255 : ((-m_prev) * 256) / (x - m_prev);
        p_ts = (((m_cnt - 1) & CMASK) << 8) | frac;
        p_first = !m_have; p_cpk = m_max;
        m_have = 1; m_gap = 0; m_max = x; m_pend = 9;
      end else begin
        if (x > m_max) m_max = x;
        if (m_have) begin
          if (m_gap == PER_MAX) begin
            m_have = 0; m_acc = 0; m_n = 0; m_perok = 0; m_ampok = 0;
          end else m_gap++;
        end
      end
      m_prev = x; m_pvld = 1; m_cnt = (m_cnt + 1) & CMASK;
    end
  endtask

  task automatic compare();
    chk("R1 s_ready", int'(s_ready), int'(m_pend == 0));
    chk("R2 xing_stb", int'(xing_stb), int'(e_xs));
    if (e_xs) chk("R3 xing_ts", int'(xing_ts), e_ts);
    chk("R4 period_stb", int'(period_stb), int'(e_ps));
    if (e_ps) chk("R4 period", int'(period), e_per);
    chk("R6 peak_stb", int'(peak_stb), int'(e_ks));
    if (e_ks) chk("R5 peak_avg", int'(peak_avg), e_avg);
    chk("R9 present", int'(present), int'(m_perok && m_ampok));
    if (xing_stb) seen_ts = int'(xing_ts);
    if (peak_stb) seen_avg = int'(peak_avg);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic cyc(bit v, int x, output bit accepted);
    compare();
    s_valid = v;
    s_data = x[DATA_W-1:0];
    accepted = v && s_ready;
    model_step(accepted, x);
    @(negedge clk);
  endtask

  task automatic send(int x);
    bit a;
    do cyc(1'b1, x, a); while (!a);
  endtask

  task automatic idle(int n);
    bit a;
    for (int i = 0; i < n; i++) cyc(1'b0, 0, a);
  endtask

  function automatic int sval(real amp, real per, int k);
    return $rtoi(amp * $sin(6.283185307 * k / per + 0.3));
  endfunction

  task automatic sine(real amp, real per, int nsmp, bit gaps);
    for (int k = 0; k < nsmp; k++) begin
      if (gaps && (k % 5 == 2)) idle(1);
      send(sval(amp, per, k));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 xing_stb", int'(xing_stb), 0);
    chk("R11 period_stb", int'(period_stb), 0);
    chk("R11 peak_stb", int'(peak_stb), 0);
    chk("R11 present", int'(present), 0);
    chk("R11 xing_ts", int'(xing_ts), 0);
    chk("R11 peak_avg", int'(peak_avg), 0);
    chk("R11 s_ready", int'(s_ready), 1);

    // main excitation: large amplitude, non-integer period, with gaps
    sine(20000.0, 37.3, 240, 1'b0);
    sine(20000.0, 37.3, 240, 1'b1);
    idle(12);
    chk("R9 present after valid excitation", int'(present), 1);

    // R3 exact zero sample: fraction clamps to 255
    for (int j = 0; j < 3; j++)
      for (int k = 0; k < 24; k++)
        send((k < 12) ? (-1200 + 200 * k) : (1200 - 200 * (k - 12)));
    idle(12);
    chk("R3 clamp fraction at b==0", seen_ts & 255, 255);

    // R8 small amplitude fails the threshold
    sine(2000.0, 40.0, 440, 1'b0);
    idle(12);
    chk("R8 present low for small amplitude", int'(present), 0);

    // restore presence, then R10 timeout
    sine(20000.0, 30.0, 330, 1'b0);
    idle(12);
    chk("R9 present restored", int'(present), 1);
    for (int k = 0; k < PER_MAX + 5; k++) send(-5000);
    idle(2);
    chk("R10 present cleared by timeout", int'(present), 0);

    // R5/R6 known per-cycle peaks 1000..8000 -> average 4500
    for (int j = 1; j <= 8; j++) begin
      send(1000 * j); send(500 * j); send(-500); send(-500);
    end
    send(100);
    idle(12);
    chk("R6 averaged peak of 8 cycles", seen_avg, 4500);

    // R7 period too short
    sine(20000.0, 6.0, 200, 1'b0);
    idle(12);
    chk("R7 present low for short period", int'(present), 0);

    idle(4);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule